// File: doc/BRIEF.md
# Count/Compare Interval Timer

This block is a processor-side interval timer. A free-running Count register advances once for every two core clocks, and a Compare register holds a target value that only software can change. When Count reaches the Compare value, the block raises a level-sensitive timer interrupt. The interrupt stays raised until software writes Compare. Software typically acknowledges the interrupt and sets the next deadline with a single Compare write.

Software reaches both registers through a plain register-select bus. One select bit picks Count or Compare, a write strobe loads the selected register, and the read data always shows the selected register. The bus has no handshake, because every access completes in one cycle. Two inputs can stop counting. A count-disable bit halts Count at any time. A freeze-in-debug bit halts Count only while the processor reports that it is in debug mode.

Top module: `cc_timer`

## Requirements
- R1: After reset, Count reads 0, Compare reads 0xFFFFFFFF and `timer_irq` is 0.
- R2: While counting is enabled, Count increases by exactly 1 for every two clocks. The first increment after reset, or after a Count write, happens on the second enabled clock.
- R3: While `count_dis` is 1, Count and the half-rate phase both hold their values.
- R4: While `dbg_mode` and `dbg_freeze` are both 1, Count and the phase hold. When `dbg_mode` is 1 and `dbg_freeze` is 0, counting continues as normal.
- R5: A write with `reg_sel`=0 (Count) loads `reg_wdata` into Count on that clock and resets the phase to 0. Counting must be enabled for Count to advance afterwards.
- R6: Compare changes only on a write with `reg_sel`=1 (Compare). Compare can be read back when `reg_sel`=1. `reg_rdata` shows the register that `reg_sel` currently selects, with no delay.
- R7: If Count equals Compare on a clock edge and there is no Compare write in that cycle, `timer_irq` is 1 from that edge onwards. It stays 1 until a Compare write.
- R8: A Compare write sets `timer_irq` to 0 on its clock edge. If the write coincides with a match, the write takes priority.
- R9: Count wraps from 0xFFFFFFFF to 0. The wrap itself does not raise `timer_irq`.
- R10: A Count write that loads the current Compare value raises `timer_irq` one clock after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 = Count, 1 = Compare |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| count_dis | input | 1 | 1 halts Count |
| dbg_mode | input | 1 | Processor is in debug mode |
| dbg_freeze | input | 1 | 1 halts Count while in debug mode |
| timer_irq | output | 1 | Sticky match interrupt |

## Verification
On every cycle, the assertions check the following:
- A Compare write clears the interrupt.
- The interrupt holds until a Compare write.
- An unmasked match sets the interrupt.
- A Count write lands exactly.
- Count never moves by more than one step, and never moves while it is disabled.
- Compare never changes without a write.

Only the bench's scenarios can show the exact half-rate cadence. They also show the debug-freeze qualification by `dbg_mode`, a write colliding with a match, a wrap with no interrupt, and a Count write that lands on the Compare value.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int unsigned TMR_W = 32;

  typedef enum logic {
    SEL_COUNT   = 1'b0,
    SEL_COMPARE = 1'b1
  } cc_sel_e;
endpackage

// File: rtl/cc_timer_count.sv
module cc_timer_count #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  logic ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else if (ld) begin
      cnt <= ld_val;
      ph  <= 1'b0;
    end else if (run) begin
      ph <= ~ph;
      if (ph) cnt <= cnt + STEP;
    end
  end
endmodule

// File: rtl/cc_timer_match.sv
module cc_timer_match #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] cmp,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '1;
      irq <= 1'b0;
    end else begin
      if (cmp_wr) begin
        cmp <= cmp_val;
        irq <= 1'b0;
      end else if (cnt == cmp) begin
        irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int unsigned W = TMR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_sel,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         count_dis,
  input  logic         dbg_mode,
  input  logic         dbg_freeze,
  output logic         timer_irq
);
  cc_sel_e     sel;
  logic        run;
  logic        cnt_ld;
  logic        cmp_ld;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cmp_q;

  assign sel    = cc_sel_e'(reg_sel);
  assign run    = !count_dis && !(dbg_mode && dbg_freeze);
  assign cnt_ld = reg_wr && (sel == SEL_COUNT);
  assign cmp_ld = reg_wr && (sel == SEL_COMPARE);

  cc_timer_count #(.W(W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .ld     (cnt_ld),
    .ld_val (reg_wdata),
    .cnt    (cnt_q)
  );

  cc_timer_match #(.W(W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_wr  (cmp_ld),
    .cmp_val (reg_wdata),
    .cnt     (cnt_q),
    .cmp     (cmp_q),
    .irq     (timer_irq)
  );

  always_comb begin
    case (sel)
      SEL_COMPARE: reg_rdata = cmp_q;
      default:     reg_rdata = cnt_q;
    endcase
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_sel,
  input logic         reg_wr,
  input logic [W-1:0] reg_wdata,
  input logic         count_dis,
  input logic         timer_irq,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp
);
  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  // R8: a Compare write clears the interrupt
  assert_cmp_wr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> !timer_irq);

  // R7: the interrupt is sticky until a Compare write
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_irq && !(reg_wr && reg_sel)) |=> timer_irq);

  // R7: an unmasked match raises the interrupt
  assert_match_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == cmp && !(reg_wr && reg_sel)) |=> timer_irq);

  // R5: a Count write loads exactly
  assert_cnt_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel) |=> (cnt == $past(reg_wdata)));

  // R2: without a load, Count moves by at most one step
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_sel) |=> (cnt == $past(cnt) || cnt == $past(cnt) + STEP));

  // R3: disabled Count holds
  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_dis && !(reg_wr && !reg_sel)) |=> $stable(cnt));

  // R6: Compare changes only on a write
  assert_cmp_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_sel) |=> $stable(cmp));
endmodule

bind cc_timer cc_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .count_dis (count_dis),
  .timer_irq (timer_irq),
  .cnt       (cnt_q),
  .cmp       (cmp_q)
);

// File: tb/cc_timer_bench.sv
`timescale 1ns/1ps
module cc_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        count_dis = 1'b0;
  logic        dbg_mode = 1'b0;
  logic        dbg_freeze = 1'b0;
  logic        timer_irq;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // behavioural reference state
  longint m_cnt = 0;
  longint m_cmp = 64'hFFFF_FFFF;
  bit     m_ph  = 1'b0;
  bit     m_irq = 1'b0;

  always #4 clk = ~clk;

  cc_timer u_cc_timer (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_dis(count_dis),
    .dbg_mode(dbg_mode), .dbg_freeze(dbg_freeze), .timer_irq(timer_irq)
  );

  always @(posedge clk) begin
    longint n_cnt, n_cmp;
    bit n_ph, n_irq, go;
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 64'hFFFF_FFFF; m_ph = 0; m_irq = 0;
    end else begin
      go = !count_dis && !(dbg_mode && dbg_freeze);
      n_cnt = m_cnt; n_cmp = m_cmp; n_ph = m_ph; n_irq = m_irq;
      if (reg_wr && reg_sel) begin n_cmp = reg_wdata; n_irq = 0; end
      else if (m_cnt == m_cmp) n_irq = 1;
      if (reg_wr && !reg_sel) begin n_cnt = reg_wdata; n_ph = 0; end
      else if (go) begin
        if (m_ph) n_cnt = (m_cnt + 1) % 64'h1_0000_0000;
        n_ph = !m_ph;
      end
      m_cnt = n_cnt; m_cmp = n_cmp; m_ph = n_ph; m_irq = n_irq;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock, then compare against the model
  task automatic cyc();
    @(posedge clk);
    #2;
    chk(cur_req, "irq", timer_irq, m_irq);
    chk(cur_req, "rdata", reg_rdata, reg_sel ? m_cmp : m_cnt);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd(bit sel, string req, longint exp);
    reg_sel = sel;
    #1;
    chk(req, "readback", reg_rdata, exp);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run(3);
    rst_n = 1'b1;
    count_dis = 1'b1;
    cyc();
    // R1 reset state
    rd(0, "R1", 0);
    rd(1, "R1", 32'hFFFF_FFFF);
    chk("R1", "irq", timer_irq, 0);
    count_dis = 1'b0;

    // R2 half-rate counting from phase 0
    cur_req = "R2"; reg_sel = 0;
    run(20);
    rd(0, "R2", 10);
    run(1);
    rd(0, "R2", 10);
    run(1);
    rd(0, "R2", 11);

    // R3 disable holds value and phase
    cur_req = "R3"; count_dis = 1'b1;
    run(9);
    rd(0, "R3", 11);
    count_dis = 1'b0;
    run(2);
    rd(0, "R3", 12);

    // R4 debug freeze qualified by debug mode
    cur_req = "R4"; dbg_freeze = 1'b1;
    run(4);
    rd(0, "R4", 14);
    dbg_mode = 1'b1;
    run(8);
    rd(0, "R4", 14);
    dbg_freeze = 1'b0;
    run(6);
    rd(0, "R4", 17);
    dbg_mode = 1'b0;

    // R5 Count load resets phase
    cur_req = "R5";
    wr(0, 32'h1234);
    rd(0, "R5", 32'h1234);
    run(1);
    rd(0, "R5", 32'h1234);
    run(1);
    rd(0, "R5", 32'h1235);

    // R6 Compare write and readback, no self change
    cur_req = "R6";
    wr(1, 32'h0000_0100);
    run(10);
    rd(1, "R6", 32'h100);

    // R7 match raises sticky irq
    cur_req = "R7";
    wr(0, 32'h0000_00F0);
    run(32);
    chk("R7", "irq before match", timer_irq, 0);
    run(2);
    chk("R7", "irq at match", timer_irq, 1);
    run(30);
    chk("R7", "irq sticky", timer_irq, 1);

    // R8 Compare write clears, wins over coincident match
    cur_req = "R8";
    wr(1, 32'h0000_8000);
    chk("R8", "irq cleared", timer_irq, 0);
    count_dis = 1'b1;
    wr(1, 32'h0000_0500);
    wr(0, 32'h0000_0500);
    wr(1, 32'h0000_0600);
    chk("R8", "irq coincident", timer_irq, 0);
    run(4);
    chk("R8", "irq after", timer_irq, 0);
    count_dis = 1'b0;

    // R9 wrap without interrupt
    cur_req = "R9";
    wr(1, 32'h0000_0010);
    wr(0, 32'hFFFF_FFFE);
    run(6);
    rd(0, "R9", 1);
    chk("R9", "irq on wrap", timer_irq, 0);

    // R10 Count load onto Compare
    cur_req = "R10";
    count_dis = 1'b1;
    wr(1, 32'h0000_0777);
    wr(0, 32'h0000_0777);
    chk("R10", "irq same edge", timer_irq, 0);
    run(1);
    chk("R10", "irq next edge", timer_irq, 1);
    count_dis = 1'b0;
    run(4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule